// File: doc/BRIEF.md
# Narrow-Strobe Bus Capture Synchronizer

This block moves a multi-bit word from a sender that has no clock relationship with the local system clock. The sender places a word on the bus and then raises a strobe. The strobe may be far shorter than one system clock period. A flag flop is clocked by the strobe itself with its data input tied high, so even a glitch-width strobe sets the flag.

A two-flop chain on the system clock carries the flag into the local domain. The second stage of that chain clears the flag asynchronously once the local domain has seen it. A rising-edge detector on the chain output produces a single-cycle load enable. That enable copies the bus into a word register, and a valid pulse accompanies the new word.

A parameter selects a reduced mode for senders whose strobe always lasts at least one clock period. In that mode the strobe feeds the synchronizer chain directly and the flag flop is absent. The sender must hold the bus steady from the strobe edge until the word has been taken. It must also leave at least four clock cycles between strobes.

Top module: `pulse_bus_capture`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it falls, `data_o` reads all zeros and `valid_o` reads 0.
- R2: In narrow mode, a strobe high pulse of 0.5 ns to 2 ns that starts between two clock edges is captured. `data_o` takes the bus value and `valid_o` rises on the third rising clock edge after the strobe's rising edge.
- R3: `valid_o` is high for exactly one clock cycle per strobe event and is never high in two consecutive cycles.
- R4: In narrow mode, several strobe pulses that all fall before the next rising clock edge produce exactly one capture.
- R5: While `valid_o` is low, `data_o` does not change. Bus activity without a strobe has no effect on `data_o` or `valid_o`.
- R6: In wide mode (`MODE` = STROBE_WIDE), a strobe held high for 1 to 4 clock periods yields exactly one capture. It appears on the third rising edge after the strobe rises.
- R7: In narrow mode, the flag is cleared once the second synchronizer stage is high. A later strobe that arrives at least four cycles after the previous one is captured again.
- R8: The bus width is the parameter `WIDTH` (default 8), and every bit of the bus is carried to `data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Active-high reset, synchronous except for the flag clear |
| strobe_i | input | 1 | Asynchronous strobe from the sender; the rising edge marks a new word |
| bus_i | input | WIDTH | Word from the sender, held stable until captured |
| data_o | output | WIDTH | Captured word, held between events |
| valid_o | output | 1 | One-cycle pulse marking a newly captured word |

## Verification
Every result is due a fixed number of clock edges after the strobe rises between two edges: the flag, two synchronizer flops and the output register put the new word and its valid pulse on the third rising edge. The bench drives the strobe 2 ns after a falling edge. It then samples at each of the following eight falling edges. A single valid pulse must appear at the third sample, and the old word must still be present at the second. The quiet cycles after each event leave time for the flag clear to release before the next strobe.

// File: rtl/bcs_pkg.sv
`timescale 1ns/100ps
package bcs_pkg;
  // Strobe handling variant
  typedef enum logic {
    STROBE_NARROW = 1'b0,  // strobe may be shorter than a clock period
    STROBE_WIDE   = 1'b1   // strobe is at least one clock period wide
  } strobe_mode_e;

  // Number of system-clock flops between the flag and the edge detector
  localparam int unsigned SYNC_DEPTH = 2;
  // Stage whose output clears the strobe-clocked flag
  localparam int unsigned CLEAR_STAGE = 1;
endpackage

// File: rtl/bcs_flag_catch.sv
`timescale 1ns/100ps
module bcs_flag_catch #(
  parameter bcs_pkg::strobe_mode_e MODE = bcs_pkg::STROBE_NARROW
) (
  input  logic rst_i,
  input  logic strobe_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (MODE == bcs_pkg::STROBE_NARROW) begin : g_narrow
      logic flag_q;
      logic clear_w;
      assign clear_w = rst_i | clr_i;
      // Clocked by the strobe with D tied high: any edge sets the flag
      always_ff @(posedge strobe_i or posedge clear_w) begin
        if (clear_w) flag_q <= 1'b0;
        else         flag_q <= 1'b1;
      end
      assign flag_o = flag_q;
    end else begin : g_wide
      // Wide strobe: first synchronizer stage samples the strobe directly
      logic unused_clear;
      assign unused_clear = rst_i | clr_i;
      assign flag_o = strobe_i;
    end
  endgenerate
endmodule

// File: rtl/bcs_sync_chain.sv
`timescale 1ns/100ps
module bcs_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q;
endmodule

// File: rtl/bcs_edge_oneshot.sv
`timescale 1ns/100ps
module bcs_edge_oneshot (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic pulse_o
);
  logic hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) hist_q <= 1'b0;
    else       hist_q <= level_i;
  end

  assign pulse_o = level_i & ~hist_q;
endmodule

// File: rtl/bcs_capture_reg.sv
`timescale 1ns/100ps
module bcs_capture_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] word_q;
  logic             valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) word_q <= bus_i;
    end
  end

  assign data_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pulse_bus_capture.sv
`timescale 1ns/100ps
module pulse_bus_capture #(
  parameter int unsigned           WIDTH = 8,
  parameter bcs_pkg::strobe_mode_e MODE  = bcs_pkg::STROBE_NARROW
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  localparam int unsigned DEPTH = bcs_pkg::SYNC_DEPTH;
  localparam int unsigned LAST  = DEPTH - 1;

  logic             flag_w;
  logic [DEPTH-1:0] sync_w;
  logic             load_w;

  bcs_flag_catch #(.MODE(MODE)) flag_i (
    .rst_i   (rst_i),
    .strobe_i(strobe_i),
    .clr_i   (sync_w[bcs_pkg::CLEAR_STAGE]),
    .flag_o  (flag_w)
  );

  bcs_sync_chain #(.STAGES(DEPTH)) sync_i (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  (flag_w),
    .q_o  (sync_w)
  );

  bcs_edge_oneshot edge_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .level_i(sync_w[LAST]),
    .pulse_o(load_w)
  );

  bcs_capture_reg #(.WIDTH(WIDTH)) cap_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load_w),
    .bus_i  (bus_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/bcs_capture_chk.sv
`timescale 1ns/100ps
module bcs_capture_chk #(
  parameter int unsigned           WIDTH = 8,
  parameter bcs_pkg::strobe_mode_e MODE  = bcs_pkg::STROBE_NARROW
) (
  input logic                          clk_i,
  input logic                          rst_i,
  input logic                          flag_i,
  input logic [bcs_pkg::SYNC_DEPTH-1:0] sync_i,
  input logic [WIDTH-1:0]              data_i,
  input logic                          valid_i
);
  logic rst_d;
  always_ff @(posedge clk_i) rst_d <= rst_i;

  // R1: outputs are cleared in the cycle after reset
  always_ff @(posedge clk_i) begin
    if (rst_d) begin
      p_reset_clear_r1: assert (!valid_i && data_i == '0)
        else $error("R1 outputs not cleared after reset");
    end
  end

  // R2: a new synchronized level produces a valid pulse one edge later
  p_sync_to_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sync_i[bcs_pkg::SYNC_DEPTH-1]) |=> valid_i);

  // R3: valid never lasts two cycles
  p_single_valid_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> !valid_i);

  // R5: word only changes alongside valid
  p_hold_word_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |-> $stable(data_i));

  // R2: valid is always preceded by a high synchronized level
  p_valid_source_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |-> $past(sync_i[bcs_pkg::SYNC_DEPTH-1]));

  generate
    if (MODE == bcs_pkg::STROBE_NARROW) begin : g_narrow_chk
      // R7: flag is held cleared while the clearing stage is high
      p_flag_cleared_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i[bcs_pkg::CLEAR_STAGE] |-> !flag_i);
    end
  endgenerate
endmodule

bind pulse_bus_capture bcs_capture_chk #(.WIDTH(WIDTH), .MODE(MODE)) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .flag_i (flag_w),
  .sync_i (sync_w),
  .data_i (data_o),
  .valid_i(valid_o)
);

// File: tb/pulse_bus_capture_tb.sv
`timescale 1ns/100ps
module pulse_bus_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int LAT        = 3;   // rising edges from strobe to output (R2, R6)
  localparam int WIN        = 8;   // observation window per event
  localparam int N_RAND     = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         strobe_n = 1'b0;
  logic         strobe_w = 1'b0;
  logic [W-1:0] bus = '0;
  logic [W-1:0] data_n, data_w;
  logic         valid_n, valid_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_bus_capture #(.WIDTH(W), .MODE(bcs_pkg::STROBE_NARROW)) dut_i (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe_n), .bus_i(bus),
    .data_o(data_n), .valid_o(valid_n)
  );

  pulse_bus_capture #(.WIDTH(W), .MODE(bcs_pkg::STROBE_WIDE)) dut_w_i (
    .clk_i(clk), .rst_i(rst), .strobe_i(strobe_w), .bus_i(bus),
    .data_o(data_w), .valid_o(valid_w)
  );

  function automatic logic [W-1:0] rand_word();
    return W'($urandom());
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cur_data(input bit wide);
    return wide ? data_w : data_n;
  endfunction

  function automatic logic cur_valid(input bit wide);
    return wide ? valid_w : valid_n;
  endfunction

  // width: narrow = units of 0.5 ns per pulse, wide = clock periods
  task automatic run_event(input bit wide, input logic [W-1:0] val,
                           input int width, input int pulses, input string req);
    int hits = 0;
    int pos  = 0;
    logic [W-1:0] got  = '0;
    logic [W-1:0] prev;
    @(negedge clk);
    prev = cur_data(wide);
    bus  = val;
    fork
      begin
        #2;
        if (wide) begin
          strobe_w = 1'b1;
          #(width * CLK_PERIOD);
          strobe_w = 1'b0;
        end else begin
          for (int g = 0; g < pulses; g++) begin
            strobe_n = 1'b1;
            #(width * 0.5);
            strobe_n = 1'b0;
            #0.5;
          end
        end
      end
      begin
        for (int k = 1; k <= WIN; k++) begin
          @(negedge clk);
          if (k == LAT - 1)
            check(cur_data(wide) == prev, req, "word changed early", cur_data(wide), prev);
          if (cur_valid(wide)) begin
            hits++;
            if (pos == 0) begin
              pos = k;
              got = cur_data(wide);
            end
          end
        end
      end
    join
    check(hits == 1, req, "valid pulse count", hits, 1);
    check(pos == LAT, req, "valid edge index", pos, LAT);
    check(got == val, req, "captured word", got, val);
  endtask

  // R5: bus moves with no strobe; nothing may change
  task automatic idle_check(input bit wide);
    logic [W-1:0] held;
    int seen = 0;
    @(negedge clk);
    held = cur_data(wide);
    for (int k = 0; k < 6; k++) begin
      bus = rand_word();
      @(negedge clk);
      if (cur_valid(wide)) seen++;
    end
    check(cur_data(wide) == held, "R5", "word after idle bus", cur_data(wide), held);
    check(seen == 0, "R5", "valid during idle bus", seen, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 while reset is high
    check(data_n == '0 && !valid_n, "R1", "narrow during reset", {data_n, valid_n}, 0);
    check(data_w == '0 && !valid_w, "R1", "wide during reset", {data_w, valid_w}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(data_n == '0 && !valid_n, "R1", "narrow after reset", {data_n, valid_n}, 0);
    check(data_w == '0 && !valid_w, "R1", "wide after reset", {data_w, valid_w}, 0);

    // R8 all-ones, all-zeros, alternating patterns
    run_event(1'b0, 8'hFF, 1, 1, "R8");
    run_event(1'b0, 8'h00, 1, 1, "R8");
    run_event(1'b0, 8'hA5, 4, 1, "R2");
    // R4 two and three glitches before the next edge
    run_event(1'b0, 8'h3C, 1, 2, "R4");
    run_event(1'b0, 8'hC3, 1, 3, "R4");
    idle_check(1'b0);

    // R2 / R3 / R7 random back-to-back narrow events
    for (int i = 0; i < N_RAND; i++) begin
      run_event(1'b0, rand_word(), 1 + int'($urandom_range(3)), 1, "R7");
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
      end
    end

    // R6 wide-mode events, directed widths then random
    for (int w = 1; w <= 4; w++) run_event(1'b1, rand_word(), w, 1, "R6");
    idle_check(1'b1);
    for (int i = 0; i < N_RAND / 2; i++)
      run_event(1'b1, rand_word(), 1 + int'($urandom_range(3)), 1, "R3");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(50000 * CLK_PERIOD);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule